// File: doc/BRIEF.md
# Output Clock Gating and Test Control

This block sits between the per-bank skew clock generators and the output pins of a multi-bank clock driver. Each bank delivers one clock that fans out to a pair of pins. The block picks the source of each bank, which is either the bank clock or, in bypass, the reference clock with a chosen polarity. It also applies a glitch-free disable to each bank and reports whether bypass is active. Every pin is registered, so a pin follows its source one clock later.

A global disable input stops every bank except the feedback bank at its idle level. The feedback bank keeps toggling so the loop can stay locked. A three-level test input selects bypass. In its MID setting, the global disable instead stops only the banks whose select code is LL. The idle level is LOW for all banks except one: when the last bank is in its inverted mode, its idle level follows the edge-select input. A gate opens or closes only while its bank's source sits at the idle level, so no pulse is ever cut short.

Top module: `clkout_gate_ctl`

## Requirements
- R1: While reset is held, and on the first clock after it, every pin and `bypass_o` are 0.
- R2: With `test_lvl_i` LOW and `oe_dis_i` 0, each pin equals its bank's `bank_clk_i` bit from the previous clock.
- R3: With `oe_dis_i` 1 and `test_lvl_i` not MID, every bank except the feedback bank (index 2) is held at its idle level. The feedback bank keeps following its source, and its high and low runs stay the full half period.
- R4: A bank's gate changes state only in a cycle where the bank's source equals its idle level. A high pulse on an enabled bank is never shortened: with a source of half period 4 clocks, every completed high run on a pin lasts exactly 4 clocks, whatever the timing of `oe_dis_i`.
- R5: The last bank is in inverted mode when both of its select fields are HIGH. In that mode its idle level equals `edge_pos_i`, so a disabled pin sits at 1 when `edge_pos_i` is 1 and at 0 when it is 0.
- R6: With `test_lvl_i` MID and `oe_dis_i` 1, each bank whose select fields are both LOW (code LL) is held at idle, including the feedback bank. All other banks run. With `test_lvl_i` HIGH and `oe_dis_i` 1, the R3 rule applies, so the feedback bank runs even when its code is LL.
- R7: With `test_lvl_i` MID or HIGH, every enabled bank's source is the reference clock, and `bypass_o` is 1 one clock after the test level is applied.
- R8: In bypass, the source is `ref_clk_i` when `edge_pos_i` is 1 and the inverse of `ref_clk_i` when it is 0.
- R9: Three-level fields are encoded as 00 LOW, 01 MID, 10 HIGH, and 11 is taken as MID. For bank b, `sel_code_i[4b+3:4b+2]` is the upper field and `sel_code_i[4b+1:4b]` is the lower field.
- R10: The two pins of a bank always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all gating state |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_clk_i | input | NUM_BANKS | Clock from each bank's skew generator |
| ref_clk_i | input | 1 | Reference clock used in bypass |
| test_lvl_i | input | 2 | Three-level test control |
| oe_dis_i | input | 1 | Global synchronous disable request |
| edge_pos_i | input | 1 | Edge select: 1 rising, 0 falling alignment |
| sel_code_i | input | 4*NUM_BANKS | Two three-level select fields per bank |
| pin_clk_o | output | NUM_BANKS*PINS_PER_BANK | Gated pin clocks, bank b on bits [2b+1:2b] |
| bypass_o | output | 1 | Registered flag, 1 while bypass is selected |

## Verification
A disable request can arrive in the same cycle that a bank's clock is in its active phase, so the gating decision and the clock pulse compete for that cycle. The bench provokes this by toggling `oe_dis_i` after random delays of 1 to 13 clocks, over hundreds of cycles, in both normal and bypass operation. It judges the result with a monitor that measures every completed high run on every pin and every low run on the feedback pins: any run other than the full half period is a failure.

// File: rtl/ogc_pkg.sv
package ogc_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  // three-level decode: 11 folds onto MID
  function automatic lvl_e lvl_decode(input logic [1:0] raw);
    case (raw)
      2'b00:   return LVL_LOW;
      2'b10:   return LVL_HIGH;
      default: return LVL_MID;
    endcase
  endfunction

  // level a bank rests at while gated off
  function automatic logic bank_idle(input logic is_inv_bank, input lvl_e f_hi,
                                     input lvl_e f_lo, input logic edge_pos);
    if (is_inv_bank && f_hi == LVL_HIGH && f_lo == LVL_HIGH) return edge_pos;
    return 1'b0;
  endfunction

  // disable request for one bank
  function automatic logic bank_off(input logic is_fb_bank, input logic test_mid,
                                    input logic oe_dis, input lvl_e f_hi, input lvl_e f_lo);
    if (test_mid) return oe_dis && f_hi == LVL_LOW && f_lo == LVL_LOW;
    return oe_dis && !is_fb_bank;
  endfunction

endpackage

// File: rtl/ogc_mode_decode.sv
module ogc_mode_decode
  import ogc_pkg::*;
(
  input  logic [1:0] test_raw_i,
  output logic       test_mid_o,
  output logic       bypass_o
);
  lvl_e test_lvl_w;

  assign test_lvl_w = lvl_decode(test_raw_i);
  assign test_mid_o = (test_lvl_w == LVL_MID);
  assign bypass_o   = (test_lvl_w != LVL_LOW);
endmodule

// File: rtl/ogc_bank_gate.sv
module ogc_bank_gate #(
  parameter int PINS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_i,
  input  logic            idle_i,
  input  logic            off_req_i,
  output logic [PINS-1:0] pin_o
);
  logic gate_q;
  logic at_idle_w;
  logic gate_nxt_w;
  logic pin_nxt_w;

  assign at_idle_w  = (src_i == idle_i);
  assign gate_nxt_w = at_idle_w ? ~off_req_i : gate_q;
  assign pin_nxt_w  = gate_q ? src_i : idle_i;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_nxt_w;
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic pin_q;
    always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_nxt_w;
    end
    assign pin_o[p] = pin_q;
  end

  // R4: gate state moves only from a cycle where the source sat at idle
  p_gate_move_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != $past(gate_q)) |-> ($past(src_i) == $past(idle_i)));

  // R4: at idle, the request is taken on the next edge
  p_open_at_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_idle_w && !off_req_i) |=> gate_q);
  p_close_at_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_idle_w && off_req_i) |=> !gate_q);

  // R2: a closed gate parks the pin at idle, an open one follows the source
  p_closed_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |=> (pin_o[0] == $past(idle_i)));
  p_open_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |=> (pin_o[0] == $past(src_i)));

  // R10: both pins of the pair agree
  p_pair_equal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_o[PINS-1] == pin_o[0]);
endmodule

// File: rtl/clkout_gate_ctl.sv
module clkout_gate_ctl
  import ogc_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 2,
  parameter int FB_BANK       = 2,
  parameter int INV_BANK      = NUM_BANKS - 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_BANKS-1:0]               bank_clk_i,
  input  logic                               ref_clk_i,
  input  logic [1:0]                         test_lvl_i,
  input  logic                               oe_dis_i,
  input  logic                               edge_pos_i,
  input  logic [4*NUM_BANKS-1:0]             sel_code_i,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_clk_o,
  output logic                               bypass_o
);
  localparam int SEL_W = 4;
  localparam int FLD_W = SEL_W / 2;

  logic test_mid_w;
  logic bypass_w;
  logic ref_src_w;
  logic bypass_q;

  ogc_mode_decode u_mode (
    .test_raw_i (test_lvl_i),
    .test_mid_o (test_mid_w),
    .bypass_o   (bypass_w)
  );

  assign ref_src_w = edge_pos_i ? ref_clk_i : ~ref_clk_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    lvl_e f_hi_w;
    lvl_e f_lo_w;
    logic src_w;
    logic idle_w;
    logic off_w;

    assign f_hi_w = lvl_decode(sel_code_i[SEL_W*b+FLD_W +: FLD_W]);
    assign f_lo_w = lvl_decode(sel_code_i[SEL_W*b +: FLD_W]);
    assign src_w  = bypass_w ? ref_src_w : bank_clk_i[b];
    assign idle_w = bank_idle(b == INV_BANK, f_hi_w, f_lo_w, edge_pos_i);
    assign off_w  = bank_off(b == FB_BANK, test_mid_w, oe_dis_i, f_hi_w, f_lo_w);

    ogc_bank_gate #(.PINS(PINS_PER_BANK)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_w),
      .idle_i    (idle_w),
      .off_req_i (off_w),
      .pin_o     (pin_clk_o[b*PINS_PER_BANK +: PINS_PER_BANK])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bypass_q <= 1'b0;
    else        bypass_q <= bypass_w;
  end
  assign bypass_o = bypass_q;

  // R7: flag tracks the test level one clock later
  p_bypass_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_lvl_i != 2'b00) |=> bypass_o);
  p_bypass_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_lvl_i == 2'b00) |=> !bypass_o);
endmodule

// File: tb/clkout_gate_ctl_tb_top.sv
`timescale 1ns/1ps
module clkout_gate_ctl_tb_top;
  localparam int NB = 4;
  localparam int NP = 8;
  localparam int FB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] bank_clk = '0;
  logic          ref_clk = 1'b0;
  logic [1:0]    test_lvl = 2'b00;
  logic          oe_dis = 1'b0;
  logic          edge_pos = 1'b1;
  logic [15:0]   sel_code = 16'h5555;
  logic [NP-1:0] pins;
  logic          bypass;

  int  checks = 0;
  int  failures = 0;
  int  cnt = 0;
  bit  inv_mode = 1'b0;
  bit  mon_en = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  clkout_gate_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bank_clk_i(bank_clk), .ref_clk_i(ref_clk),
    .test_lvl_i(test_lvl), .oe_dis_i(oe_dis), .edge_pos_i(edge_pos),
    .sel_code_i(sel_code), .pin_clk_o(pins), .bypass_o(bypass));

  // source clocks: period 8, bank b phase-shifted by b, updated just after each edge
  always @(posedge clk) begin
    #1;
    cnt = (cnt + 1) % 8;
    ref_clk = (cnt < 4);
    for (int b = 0; b < NB; b++) begin
      logic bc;
      bc = (((cnt + b) % 8) < 4);
      if (inv_mode && b == 3) bc = ~bc;
      bank_clk[b] = bc;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_src(input int b);
    if (test_lvl != 2'b00) return edge_pos ? ref_clk : ~ref_clk;
    return bank_clk[b];
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // compare pins against last cycle's source (run) or a held level
  task automatic watch(input string req, input int n, input logic [3:0] run, input logic [3:0] held);
    logic [3:0] prev;
    logic [7:0] e;
    @(negedge clk);
    for (int b = 0; b < NB; b++) prev[b] = exp_src(b);
    repeat (n) begin
      @(negedge clk);
      for (int b = 0; b < NB; b++) begin
        e[2*b]   = run[b] ? prev[b] : held[b];
        e[2*b+1] = e[2*b];
      end
      check(req, pins, e);
      for (int b = 0; b < NB; b++) prev[b] = exp_src(b);
    end
  endtask

  // pulse-width monitor
  int   run_len [NP];
  bit   seen [NP];
  logic prev_pin [NP];
  always @(negedge clk) begin
    if (mon_en) begin
      for (int p = 0; p < NP; p++) begin
        if (pins[p] === prev_pin[p]) run_len[p]++;
        else begin
          if (seen[p] && prev_pin[p] === 1'b1) check("R4 high run", 8'(run_len[p]), 8'd4);
          if (seen[p] && prev_pin[p] === 1'b0 && p / 2 == FB) check("R3 fb low run", 8'(run_len[p]), 8'd4);
          seen[p] = 1'b1;
          run_len[p] = 1;
        end
        prev_pin[p] = pins[p];
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        seen[p] = 1'b0; run_len[p] = 0; prev_pin[p] = pins[p];
      end
    end
  end

  task automatic t_reset();
    settle(3);
    check("R1 pins in reset", pins, 8'h00);
    check("R1 bypass in reset", {7'd0, bypass}, 8'h00);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 pins after reset", pins, 8'h00);
    check("R1 bypass after reset", {7'd0, bypass}, 8'h00);
  endtask

  task automatic t_normal();
    test_lvl = 2'b00; oe_dis = 1'b0; sel_code = 16'h5555; edge_pos = 1'b1;
    settle(20);
    watch("R2 normal follow", 16, 4'hF, 4'h0);
    check("R7 no bypass at LOW", {7'd0, bypass}, 8'h00);
    repeat (8) begin
      @(negedge clk);
      for (int b = 0; b < NB; b++) check("R10 pair equal", {7'd0, pins[2*b+1]}, {7'd0, pins[2*b]});
    end
  endtask

  task automatic t_global_off();
    oe_dis = 1'b1; settle(20);
    watch("R3 global off", 16, 4'b0100, 4'h0);
    oe_dis = 1'b0; settle(20);
  endtask

  task automatic t_inverted();
    inv_mode = 1'b1; sel_code = 16'hA555; edge_pos = 1'b1; oe_dis = 1'b1;
    settle(20);
    watch("R5 inverted idle high", 16, 4'b0100, 4'b1000);
    edge_pos = 1'b0; settle(20);
    watch("R5 inverted idle low", 16, 4'b0100, 4'b0000);
    oe_dis = 1'b0; settle(20);
    watch("R5 inverted running", 16, 4'hF, 4'h0);
    inv_mode = 1'b0; sel_code = 16'h5555; edge_pos = 1'b1; settle(20);
  endtask

  task automatic t_test_mid();
    test_lvl = 2'b01; oe_dis = 1'b1; sel_code = 16'h5005; edge_pos = 1'b1;
    settle(20);
    watch("R6 mid LL banks off", 16, 4'b1001, 4'h0);
    check("R7 bypass at MID", {7'd0, bypass}, 8'h01);
    test_lvl = 2'b11; settle(20);
    watch("R9 code 11 as MID", 16, 4'b1001, 4'h0);
    test_lvl = 2'b10; settle(20);
    watch("R6 HIGH uses global rule", 16, 4'b0100, 4'h0);
    oe_dis = 1'b0; sel_code = 16'h5555; settle(20);
  endtask

  task automatic t_bypass();
    test_lvl = 2'b10; oe_dis = 1'b0; edge_pos = 1'b1; settle(20);
    watch("R7 bypass ref rising", 16, 4'hF, 4'h0);
    check("R7 bypass flag HIGH", {7'd0, bypass}, 8'h01);
    edge_pos = 1'b0; settle(20);
    watch("R8 bypass ref falling", 16, 4'hF, 4'h0);
    edge_pos = 1'b1; test_lvl = 2'b00; settle(20);
    check("R7 bypass flag cleared", {7'd0, bypass}, 8'h00);
  endtask

  task automatic t_glitch(input logic [1:0] lvl);
    test_lvl = lvl; oe_dis = 1'b0; sel_code = 16'h5555; edge_pos = 1'b1;
    settle(20);
    mon_en = 1'b1;
    repeat (60) begin
      settle($urandom_range(1, 13));
      oe_dis = ~oe_dis;
    end
    oe_dis = 1'b0; settle(24);
    mon_en = 1'b0; settle(2);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired act=running exp=done");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_normal();
    t_global_off();
    t_inverted();
    t_test_mid();
    t_bypass();
    t_glitch(2'b00);
    t_glitch(2'b10);
    done = 1'b1;
    finish_run();
  end
endmodule